// File: doc/BRIEF.md
# Dual Serial Flash Lane Router

This block sits between a quad-lane serial shift engine and two identical serial flash devices. The engine has one chip select and one set of data lines. A three-field configuration word selects how these reach the devices. In single mode only the lower device is used. In stacked mode the chip select and four data lines go to one device at a time, and a page bit picks which one. In parallel mode both devices are selected together and each carries half of every byte: the even-numbered bits go to the lower device and the odd-numbered bits go to the upper device.

The engine presents eight data-out lines, eight per-line output enables and eight data-in lines. Single and stacked modes use only lines 3:0. Parallel mode uses all eight, so one serial clock moves one full byte. Each device has its own active-low chip select, four data-out lines, four output enables and four data-in lines. All routing is combinational from the active configuration. The configuration register is the only state. A configuration write never changes the routing in the middle of a transfer: a write that arrives while the engine's chip select is asserted is held, and it takes effect once the chip select is released.

Top module: `flash_lane_router`

## Requirements
- R1: After reset the configuration is all clear. The block is in single mode, the upper chip select is high and all upper output enables are low.
- R2: In single mode (bit 30 of the configuration word clear) the lower chip select follows the engine's chip select. Engine lines 3:0 (data and enable) pass to the lower device. The upper chip select stays high and its enables stay low. Engine data-in 3:0 is the lower device's input and 7:4 reads zero. Bits 29 and 28 have no effect in this mode.
- R3: In stacked mode (bit 30 set, bit 29 clear) with the page bit (bit 28) clear, the lower device receives the chip select and lines 3:0. The upper device is deselected and tri-stated.
- R4: In stacked mode with the page bit set, the upper device receives the chip select and lines 3:0. The lower chip select is held high and its enables are low.
- R5: In stacked mode, engine data-in 3:0 reflects only the selected device's inputs, and data-in 7:4 reads zero. The unselected device's inputs have no effect.
- R6: In parallel mode (bits 30 and 29 set) both chip selects follow the engine's chip select, and the page bit has no effect.
- R7: In parallel mode, device line k of the lower device carries engine line 2k and device line k of the upper device carries engine line 2k+1, for both data and output enable.
- R8: In parallel mode, engine data-in bit 2k is the lower device's input line k and bit 2k+1 is the upper device's input line k.
- R9: A configuration write that is sampled while the engine chip select is low does not change the routing. It is applied on the first clock edge at which the chip select is sampled high, and the latest held write wins.
- R10: A configuration write that is sampled while the engine chip select is high takes effect from the next clock edge and discards any held write.
- R11: Whenever the engine chip select is high, both device chip selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration word (bit 30 two devices, bit 29 separate buses, bit 28 upper page) |
| ctl_cs_ni | input | 1 | Engine chip select, active low |
| ctl_do_i | input | 8 | Engine data-out lines |
| ctl_oe_i | input | 8 | Engine per-line output enables |
| ctl_di_o | output | 8 | Data-in lines returned to the engine |
| lo_cs_no | output | 1 | Lower device chip select, active low |
| lo_do_o | output | 4 | Lower device data-out lines |
| lo_oe_o | output | 4 | Lower device output enables |
| lo_di_i | input | 4 | Lower device data-in lines |
| up_cs_no | output | 1 | Upper device chip select, active low |
| up_do_o | output | 4 | Upper device data-out lines |
| up_oe_o | output | 4 | Upper device output enables |
| up_di_i | input | 4 | Upper device data-in lines |

## Verification
The hardest case to reach is a configuration change arriving in the middle of a transfer. The bench keeps the chip select low across several writes and checks that the routing stays put. It then releases the chip select and checks that the last held word takes effect on that exact edge. A second run holds the chip select low, leaves a write pending and then issues a fresh write while idle, which must replace the pending one. In stacked mode the bench drives different values on the two devices' input lines, so that a wrong return path shows at the engine side.

// File: rtl/flr_pkg.sv
package flr_pkg;
  typedef struct packed {
    logic two_mem;
    logic sep_bus;
    logic upage;
  } cfg_t;

  typedef enum logic [1:0] {
    ROUTE_SINGLE   = 2'd0,
    ROUTE_STACK_LO = 2'd1,
    ROUTE_STACK_UP = 2'd2,
    ROUTE_PAIR     = 2'd3
  } route_e;

  function automatic route_e decode_route(cfg_t c);
    if (!c.two_mem)     return ROUTE_SINGLE;
    else if (c.sep_bus) return ROUTE_PAIR;
    else if (c.upage)   return ROUTE_STACK_UP;
    else                return ROUTE_STACK_LO;
  endfunction
endpackage

// File: rtl/flr_cfg.sv
module flr_cfg #(
  parameter int CFG_W       = 32,
  parameter int TWO_MEM_BIT = 30,
  parameter int SEP_BUS_BIT = 29,
  parameter int UPAGE_BIT   = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CFG_W-1:0]  wdata_i,
  input  logic              cs_ni,
  output flr_pkg::cfg_t     cfg_o
);
  flr_pkg::cfg_t wr_cfg, cfg_q, pend_q;
  logic          pend_vld_q;
  logic          unused_wdata;

  assign wr_cfg = '{two_mem: wdata_i[TWO_MEM_BIT],
                    sep_bus: wdata_i[SEP_BUS_BIT],
                    upage:   wdata_i[UPAGE_BIT]};
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
    end else if (wr_i && cs_ni) begin
      cfg_q      <= wr_cfg;
      pend_vld_q <= 1'b0;
    end else if (wr_i) begin
      pend_q     <= wr_cfg;
      pend_vld_q <= 1'b1;
    end else if (cs_ni && pend_vld_q) begin
      cfg_q      <= pend_q;
      pend_vld_q <= 1'b0;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/flr_cs_route.sv
module flr_cs_route (
  input  flr_pkg::route_e route_i,
  input  logic            cs_ni,
  output logic            lo_cs_no,
  output logic            up_cs_no
);
  logic lo_sel, up_sel;

  always_comb begin
    lo_sel = 1'b0;
    up_sel = 1'b0;
    unique case (route_i)
      flr_pkg::ROUTE_SINGLE,
      flr_pkg::ROUTE_STACK_LO: lo_sel = 1'b1;
      flr_pkg::ROUTE_STACK_UP: up_sel = 1'b1;
      flr_pkg::ROUTE_PAIR: begin
        lo_sel = 1'b1;
        up_sel = 1'b1;
      end
      default: ;
    endcase
  end

  assign lo_cs_no = cs_ni | ~lo_sel;
  assign up_cs_no = cs_ni | ~up_sel;
endmodule

// File: rtl/flr_lane_route.sv
module flr_lane_route #(
  parameter int NIB_W = 4,
  localparam int BUS_W = 2 * NIB_W
) (
  input  flr_pkg::route_e   route_i,
  input  logic [BUS_W-1:0]  ctl_do_i,
  input  logic [BUS_W-1:0]  ctl_oe_i,
  output logic [BUS_W-1:0]  ctl_di_o,
  output logic [NIB_W-1:0]  lo_do_o,
  output logic [NIB_W-1:0]  lo_oe_o,
  input  logic [NIB_W-1:0]  lo_di_i,
  output logic [NIB_W-1:0]  up_do_o,
  output logic [NIB_W-1:0]  up_oe_o,
  input  logic [NIB_W-1:0]  up_di_i
);
  logic [NIB_W-1:0] ev_do, od_do, ev_oe, od_oe;
  logic [BUS_W-1:0] pair_di;

  // even engine lines to lower device, odd to upper
  for (genvar g = 0; g < NIB_W; g++) begin : g_split
    assign ev_do[g]       = ctl_do_i[2*g];
    assign od_do[g]       = ctl_do_i[2*g+1];
    assign ev_oe[g]       = ctl_oe_i[2*g];
    assign od_oe[g]       = ctl_oe_i[2*g+1];
    assign pair_di[2*g]   = lo_di_i[g];
    assign pair_di[2*g+1] = up_di_i[g];
  end

  always_comb begin
    lo_do_o  = '0;
    lo_oe_o  = '0;
    up_do_o  = '0;
    up_oe_o  = '0;
    ctl_di_o = '0;
    unique case (route_i)
      flr_pkg::ROUTE_SINGLE,
      flr_pkg::ROUTE_STACK_LO: begin
        lo_do_o  = ctl_do_i[NIB_W-1:0];
        lo_oe_o  = ctl_oe_i[NIB_W-1:0];
        ctl_di_o = {{NIB_W{1'b0}}, lo_di_i};
      end
      flr_pkg::ROUTE_STACK_UP: begin
        up_do_o  = ctl_do_i[NIB_W-1:0];
        up_oe_o  = ctl_oe_i[NIB_W-1:0];
        ctl_di_o = {{NIB_W{1'b0}}, up_di_i};
      end
      flr_pkg::ROUTE_PAIR: begin
        lo_do_o  = ev_do;
        lo_oe_o  = ev_oe;
        up_do_o  = od_do;
        up_oe_o  = od_oe;
        ctl_di_o = pair_di;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/flash_lane_router.sv
module flash_lane_router #(
  parameter int NIB_W       = 4,
  parameter int CFG_W       = 32,
  parameter int TWO_MEM_BIT = 30,
  parameter int SEP_BUS_BIT = 29,
  parameter int UPAGE_BIT   = 28,
  localparam int BUS_W = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              ctl_cs_ni,
  input  logic [BUS_W-1:0]  ctl_do_i,
  input  logic [BUS_W-1:0]  ctl_oe_i,
  output logic [BUS_W-1:0]  ctl_di_o,
  output logic              lo_cs_no,
  output logic [NIB_W-1:0]  lo_do_o,
  output logic [NIB_W-1:0]  lo_oe_o,
  input  logic [NIB_W-1:0]  lo_di_i,
  output logic              up_cs_no,
  output logic [NIB_W-1:0]  up_do_o,
  output logic [NIB_W-1:0]  up_oe_o,
  input  logic [NIB_W-1:0]  up_di_i
);
  flr_pkg::cfg_t   cfg;
  flr_pkg::route_e route;

  flr_cfg #(
    .CFG_W(CFG_W), .TWO_MEM_BIT(TWO_MEM_BIT),
    .SEP_BUS_BIT(SEP_BUS_BIT), .UPAGE_BIT(UPAGE_BIT)
  ) i_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(cfg_wr_i),
    .wdata_i(cfg_wdata_i), .cs_ni(ctl_cs_ni), .cfg_o(cfg)
  );

  assign route = flr_pkg::decode_route(cfg);

  flr_cs_route i_cs (
    .route_i(route), .cs_ni(ctl_cs_ni),
    .lo_cs_no(lo_cs_no), .up_cs_no(up_cs_no)
  );

  flr_lane_route #(.NIB_W(NIB_W)) i_lane (
    .route_i(route), .ctl_do_i(ctl_do_i), .ctl_oe_i(ctl_oe_i),
    .ctl_di_o(ctl_di_o), .lo_do_o(lo_do_o), .lo_oe_o(lo_oe_o),
    .lo_di_i(lo_di_i), .up_do_o(up_do_o), .up_oe_o(up_oe_o),
    .up_di_i(up_di_i)
  );
endmodule

// File: rtl/flr_checker.sv
module flr_checker #(
  parameter int NIB_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input flr_pkg::cfg_t    cfg,
  input logic             ctl_cs_ni,
  input logic             lo_cs_no,
  input logic             up_cs_no,
  input logic [NIB_W-1:0] lo_oe_o,
  input logic [NIB_W-1:0] up_oe_o
);
  p_idle_deselect_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_cs_ni |-> (lo_cs_no && up_cs_no));

  p_single_upper_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg.two_mem |-> (up_cs_no && up_oe_o == '0));

  p_stack_one_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.two_mem && !cfg.sep_bus) |-> (lo_cs_no || up_cs_no));

  p_stack_upper_lo_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.two_mem && !cfg.sep_bus && cfg.upage) |-> (lo_cs_no && lo_oe_o == '0));

  p_pair_same_cs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.two_mem && cfg.sep_bus) |-> (lo_cs_no == up_cs_no));

  p_hold_in_transfer_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ctl_cs_ni) |-> $stable(cfg));
endmodule

bind flash_lane_router flr_checker #(.NIB_W(NIB_W)) i_flr_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg(cfg), .ctl_cs_ni(ctl_cs_ni),
  .lo_cs_no(lo_cs_no), .up_cs_no(up_cs_no),
  .lo_oe_o(lo_oe_o), .up_oe_o(up_oe_o)
);

// File: tb/test_flash_lane_router.sv
module test_flash_lane_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        cs_n = 1'b1;
  logic [7:0]  c_do = '0, c_oe = '0;
  logic [3:0]  l_di = '0, u_di = '0;
  logic [7:0]  c_di;
  logic        l_cs, u_cs;
  logic [3:0]  l_do, l_oe, u_do, u_oe;

  int checks = 0, errors = 0;
  // reference state
  bit m_two = 0, m_sep = 0, m_pg = 0;
  bit p_two = 0, p_sep = 0, p_pg = 0, p_vld = 0;

  always #10 clk = ~clk;

  flash_lane_router i_flash_lane_router (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata),
    .ctl_cs_ni(cs_n), .ctl_do_i(c_do), .ctl_oe_i(c_oe), .ctl_di_o(c_di),
    .lo_cs_no(l_cs), .lo_do_o(l_do), .lo_oe_o(l_oe), .lo_di_i(l_di),
    .up_cs_no(u_cs), .up_do_o(u_do), .up_oe_o(u_oe), .up_di_i(u_di)
  );

  function automatic logic [3:0] pick(logic [7:0] v, int ofs);
    logic [3:0] r;
    for (int k = 0; k < 4; k++) r[k] = v[2*k+ofs];
    return r;
  endfunction

  task automatic compare(string req);
    logic [33:0] exp_v, act_v;
    logic       e_lcs = 1, e_ucs = 1;
    logic [3:0] e_ldo = 0, e_loe = 0, e_udo = 0, e_uoe = 0;
    logic [7:0] e_di = 0;
    if (!m_two || (!m_sep && !m_pg)) begin
      e_lcs = cs_n; e_ldo = c_do[3:0]; e_loe = c_oe[3:0]; e_di = {4'h0, l_di};
    end else if (!m_sep) begin
      e_ucs = cs_n; e_udo = c_do[3:0]; e_uoe = c_oe[3:0]; e_di = {4'h0, u_di};
    end else begin
      e_lcs = cs_n; e_ucs = cs_n;
      e_ldo = pick(c_do, 0); e_loe = pick(c_oe, 0);
      e_udo = pick(c_do, 1); e_uoe = pick(c_oe, 1);
      for (int k = 0; k < 4; k++) begin
        e_di[2*k] = l_di[k];
        e_di[2*k+1] = u_di[k];
      end
    end
    exp_v = {e_lcs, e_ucs, e_ldo, e_loe, e_udo, e_uoe, e_di};
    act_v = {l_cs, u_cs, l_do, l_oe, u_do, u_oe, c_di};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  // one clock: inputs already set; update model at edge, check mid-cycle
  task automatic step(string req);
    @(posedge clk);
    if (cfg_wr && cs_n) begin
      m_two = cfg_wdata[30]; m_sep = cfg_wdata[29]; m_pg = cfg_wdata[28]; p_vld = 0;
    end else if (cfg_wr) begin
      p_two = cfg_wdata[30]; p_sep = cfg_wdata[29]; p_pg = cfg_wdata[28]; p_vld = 1;
    end else if (cs_n && p_vld) begin
      m_two = p_two; m_sep = p_sep; m_pg = p_pg; p_vld = 0;
    end
    #5;
    compare(req);
    #4;
  endtask

  task automatic wr_cfg(logic [31:0] w, string req);
    cfg_wr = 1; cfg_wdata = w;
    step(req);
    cfg_wr = 0;
  endtask

  task automatic drive(logic cs, logic [7:0] d, logic [7:0] oe, logic [3:0] ld, logic [3:0] ud);
    cs_n = cs; c_do = d; c_oe = oe; l_di = ld; u_di = ud;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    #45;
    compare("R1");
    rst_n = 1;
    #4;
    drive(0, 8'h5A, 8'h0F, 4'h6, 4'h9); step("R1");
    drive(0, 8'hC3, 8'hFF, 4'hA, 4'h5); step("R2");
    drive(1, 8'h3C, 8'h0F, 4'h1, 4'hE); step("R11");
    drive(0, 8'h3C, 8'h0F, 4'h1, 4'hE);
    wr_cfg(32'h3000_0000, "R9");           // bit30 clear: still single
    drive(1, 8'h3C, 8'h0F, 4'h1, 4'hE); step("R9");
    drive(0, 8'h7E, 8'hF0, 4'h2, 4'hD); step("R2");
    // stacked, lower
    drive(1, 8'h00, 8'h00, 4'h0, 4'h0);
    wr_cfg(32'h4000_0000, "R10");
    drive(0, 8'hB6, 8'h0F, 4'h3, 4'hC); step("R3");
    drive(0, 8'hB6, 8'h0F, 4'h3, 4'h5); step("R5");
    // write upper page while busy: held
    wr_cfg(32'h5000_0000, "R9");
    drive(0, 8'h19, 8'h0F, 4'h7, 4'h8); step("R9");
    step("R9");
    drive(1, 8'h19, 8'h0F, 4'h7, 4'h8); step("R9");
    drive(0, 8'h19, 8'h0F, 4'h7, 4'h8); step("R4");
    drive(0, 8'hE2, 8'h0F, 4'hF, 4'h4); step("R5");
    // two held writes, the later wins
    wr_cfg(32'h4000_0000, "R9");
    wr_cfg(32'h6000_0000, "R9");
    drive(1, 8'hA5, 8'hFF, 4'h9, 4'h6); step("R9");
    drive(0, 8'hA5, 8'hFF, 4'h9, 4'h6); step("R7");
    drive(0, 8'h3C, 8'h55, 4'h5, 4'hA); step("R8");
    drive(0, 8'hF0, 8'hAA, 4'hC, 4'h3); step("R7");
    drive(1, 8'h0F, 8'h33, 4'h1, 4'h8);
    wr_cfg(32'h7000_0000, "R6");          // page bit has no effect
    drive(0, 8'h96, 8'hCC, 4'hB, 4'h2); step("R6");
    // held write replaced by an idle write
    wr_cfg(32'h4000_0000, "R9");
    drive(1, 8'h96, 8'hCC, 4'hB, 4'h2);
    wr_cfg(32'h5000_0000, "R10");
    step("R10");
    drive(0, 8'h96, 8'hCC, 4'hB, 4'h2); step("R4");
    for (int i = 0; i < 400; i++) begin
      string tag;
      drive(($urandom % 3) == 0, 8'($urandom), 8'($urandom), 4'($urandom), 4'($urandom));
      cfg_wr = ($urandom % 6) == 0;
      cfg_wdata = {1'b0, 3'($urandom), 28'($urandom)};
      tag = !m_two ? "R2" : (m_sep ? "R8" : (m_pg ? "R4" : "R3"));
      step(tag);
      cfg_wr = 0;
    end
    finish_run();
  end
endmodule